// File: doc/BRIEF.md
# Aliased Multi-Width Register File

This block holds sixteen 16-bit words and lets the same storage be seen at four widths: byte, word, double-word (a pair of registers) and quad-word (four registers). It has one synchronous write port and two combinational read ports. Each port carries a register index and a 2-bit width code. Read data comes back on a 64-bit bus, right-aligned and zero-extended when the access is narrower than 64 bits. A narrow write changes only the bits it covers. Everything else in the file keeps its value.

Pairs start on even indices and quads start on indices that are multiples of four. When a pair or quad is accessed, the lowest-numbered register holds the most significant word. Byte access reaches only registers 0 to 7. Each of those registers has a high-byte alias and a low-byte alias. A misaligned index raises the error output of its port, and on the write port it also blocks the write. The highest register serves as the stack pointer and has its own output.

The block has no sequencing of its own: the only state is the storage itself. A write is a single-cycle update, and reads are pure selection from the current contents.

Top module: `mwrf_top`

## Requirements
- R1: After reset all sixteen registers read as zero, and the stack-pointer output is zero.
- R2: Width code 2'b01 (word) reaches register `idx` (0 to 15). A read returns the word in bits 15:0 with bits 63:16 zero.
- R3: Width code 2'b10 (double-word) with an even `idx` maps register `idx` to bits 31:16 and register `idx+1` to bits 15:0. Read bits 63:32 are zero.
- R4: Width code 2'b11 (quad-word) with `idx` a multiple of 4 maps registers `idx`, `idx+1`, `idx+2` and `idx+3` to bits 63:48, 47:32, 31:16 and 15:0.
- R5: Width code 2'b00 (byte) decodes the 4-bit index as follows. Bits 2:0 pick register 0 to 7. Bit 3 = 1 picks bits 7:0 of that register and bit 3 = 0 picks bits 15:8. Reads return the byte in bits 7:0 with zeros above. A write changes only that byte.
- R6: A write changes only the registers and bytes its width and index cover. With `wr_en` low, nothing changes.
- R7: A double-word access with an odd index, or a quad-word access whose index is not a multiple of 4, raises that port's error output. An illegal read returns zero. An illegal write (error raised only while `wr_en` is high) leaves the storage unchanged.
- R8: A read in the same cycle as a write to the same storage returns the old contents. The new value is visible from the next cycle.
- R9: `sp_value` always equals register 15, and it reflects a write in the cycle after that write.
- R10: The two read ports are independent, and each may use any index and width at the same time as the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write enable |
| wr_idx | input | 4 | Write index |
| wr_width | input | 2 | Write width code |
| wr_data | input | 64 | Write data, right-aligned |
| wr_err | output | 1 | Write index and width are misaligned (only while `wr_en` is high) |
| rd0_idx | input | 4 | Read port 0 index |
| rd0_width | input | 2 | Read port 0 width code |
| rd0_data | output | 64 | Read port 0 data, zero-extended |
| rd0_err | output | 1 | Read port 0 misaligned |
| rd1_idx | input | 4 | Read port 1 index |
| rd1_width | input | 2 | Read port 1 width code |
| rd1_data | output | 64 | Read port 1 data, zero-extended |
| rd1_err | output | 1 | Read port 1 misaligned |
| sp_value | output | 16 | Current contents of register 15 |

## Verification
The assertions guard a set of rules on every cycle:
- a blocked or disabled write leaves the whole file untouched;
- a high-byte write leaves the low byte of its register as it was;
- a word read clears the upper 48 bits;
- a misaligned quad read raises its error and returns zero;
- a word write to register 15 shows up on the stack-pointer output one cycle later.

Other behaviour is visible only through the bench's scenarios, which compare against a model of sixteen plain words:
- that every alias lands on the right words in the right order;
- that a read in the same cycle as a write sees the old value;
- that the two read ports do not disturb each other.

// File: rtl/mwrf_pkg.sv
package mwrf_pkg;
    typedef enum logic [1:0] {
        W_BYTE  = 2'b00,
        W_WORD  = 2'b01,
        W_DWORD = 2'b10,
        W_QUAD  = 2'b11
    } width_e;
endpackage

// File: rtl/mwrf_align.sv
// Alignment check for one port: pairs need an even base, quads a base divisible by four.
module mwrf_align
    import mwrf_pkg::*;
#(
    parameter int IW = 4
) (
    input  logic [IW-1:0] idx,
    input  width_e        width,
    output logic          legal
);
    always_comb begin
        unique case (width)
            W_DWORD: legal = (idx[0] == 1'b0);
            W_QUAD:  legal = (idx[1:0] == 2'b00);
            default: legal = 1'b1;
        endcase
    end
endmodule

// File: rtl/mwrf_read_port.sv
// Combinational view of the file at one width; illegal accesses read zero.
module mwrf_read_port
    import mwrf_pkg::*;
#(
    parameter int NREG = 16,
    parameter int WW   = 16,
    localparam int IW  = $clog2(NREG),
    localparam int DW  = 4 * WW,
    localparam int HW  = WW / 2
) (
    input  logic [NREG-1:0][WW-1:0] file,
    input  logic [IW-1:0]           idx,
    input  width_e                  width,
    input  logic                    legal,
    output logic [DW-1:0]           data
);
    logic [IW-1:0] pair_base;
    logic [IW-1:0] quad_base;
    logic [IW-1:0] byte_reg;
    logic [WW-1:0] byte_src;

    assign pair_base = {idx[IW-1:1], 1'b0};
    assign quad_base = {idx[IW-1:2], 2'b00};
    assign byte_reg  = {1'b0, idx[IW-2:0]};
    assign byte_src  = file[byte_reg];

    always_comb begin
        data = '0;
        if (legal) begin
            unique case (width)
                W_BYTE:  data[HW-1:0] = idx[IW-1] ? byte_src[HW-1:0] : byte_src[WW-1:HW];
                W_WORD:  data[WW-1:0] = file[idx];
                W_DWORD: begin
                    data[2*WW-1:WW] = file[pair_base];
                    data[WW-1:0]    = file[pair_base + IW'(1)];
                end
                W_QUAD: begin
                    for (int k = 0; k < 4; k++)
                        data[(3-k)*WW +: WW] = file[quad_base + IW'(k)];
                end
            endcase
        end
    end
endmodule

// File: rtl/mwrf_bank.sv
// Storage: per-register byte-lane enables derived from the write alias.
module mwrf_bank
    import mwrf_pkg::*;
#(
    parameter int NREG = 16,
    parameter int WW   = 16,
    localparam int IW  = $clog2(NREG),
    localparam int DW  = 4 * WW,
    localparam int HW  = WW / 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    we,
    input  logic [IW-1:0]           idx,
    input  width_e                  width,
    input  logic [DW-1:0]           wdata,
    output logic [NREG-1:0][WW-1:0] file
);
    for (genvar i = 0; i < NREG; i++) begin : g_reg
        localparam int POFF = i % 2;
        localparam int QOFF = i % 4;
        localparam logic [IW-1:0] ME = IW'(i);
        logic          byte_hit;
        logic          hi_en, lo_en;
        logic [WW-1:0] nval;
        logic [WW-1:0] q;

        if (i < NREG / 2) begin : g_byte
            assign byte_hit = (idx[IW-2:0] == ME[IW-2:0]);
        end else begin : g_nobyte
            assign byte_hit = 1'b0;
        end

        always_comb begin
            hi_en = 1'b0;
            lo_en = 1'b0;
            nval  = q;
            if (we) begin
                unique case (width)
                    W_BYTE: if (byte_hit) begin
                        if (idx[IW-1]) begin
                            lo_en = 1'b1;
                            nval[HW-1:0] = wdata[HW-1:0];
                        end else begin
                            hi_en = 1'b1;
                            nval[WW-1:HW] = wdata[HW-1:0];
                        end
                    end
                    W_WORD: if (idx == ME) begin
                        hi_en = 1'b1;
                        lo_en = 1'b1;
                        nval  = wdata[WW-1:0];
                    end
                    W_DWORD: if (idx[IW-1:1] == ME[IW-1:1]) begin
                        hi_en = 1'b1;
                        lo_en = 1'b1;
                        nval  = wdata[(1-POFF)*WW +: WW];
                    end
                    W_QUAD: if (idx[IW-1:2] == ME[IW-1:2]) begin
                        hi_en = 1'b1;
                        lo_en = 1'b1;
                        nval  = wdata[(3-QOFF)*WW +: WW];
                    end
                endcase
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                q <= '0;
            end else begin
                if (hi_en) q[WW-1:HW] <= nval[WW-1:HW];
                if (lo_en) q[HW-1:0]  <= nval[HW-1:0];
            end
        end

        assign file[i] = q;
    end

    // R6: no write enable, no change anywhere
    assert_idle_keeps_file_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(file));

    // R5: a high-byte write leaves the low byte of its register alone
    assert_byte_keeps_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (we && width == W_BYTE && !idx[IW-1]) |=>
        file[{1'b0, $past(idx[IW-2:0])}][HW-1:0] ==
        $past(file[{1'b0, idx[IW-2:0]}][HW-1:0]));
endmodule

// File: rtl/mwrf_top.sv
module mwrf_top
    import mwrf_pkg::*;
#(
    parameter int NREG = 16,
    parameter int WW   = 16,
    localparam int IW  = $clog2(NREG),
    localparam int DW  = 4 * WW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_idx,
    input  logic [1:0]    wr_width,
    input  logic [DW-1:0] wr_data,
    output logic          wr_err,
    input  logic [IW-1:0] rd0_idx,
    input  logic [1:0]    rd0_width,
    output logic [DW-1:0] rd0_data,
    output logic          rd0_err,
    input  logic [IW-1:0] rd1_idx,
    input  logic [1:0]    rd1_width,
    output logic [DW-1:0] rd1_data,
    output logic          rd1_err,
    output logic [WW-1:0] sp_value
);
    logic [NREG-1:0][WW-1:0] file;
    logic wr_legal, rd0_legal, rd1_legal;

    mwrf_align #(.IW(IW)) u_wr_align (
        .idx(wr_idx), .width(width_e'(wr_width)), .legal(wr_legal));
    mwrf_align #(.IW(IW)) u_rd0_align (
        .idx(rd0_idx), .width(width_e'(rd0_width)), .legal(rd0_legal));
    mwrf_align #(.IW(IW)) u_rd1_align (
        .idx(rd1_idx), .width(width_e'(rd1_width)), .legal(rd1_legal));

    assign wr_err  = wr_en & ~wr_legal;
    assign rd0_err = ~rd0_legal;
    assign rd1_err = ~rd1_legal;

    mwrf_bank #(.NREG(NREG), .WW(WW)) u_bank (
        .clk(clk), .rst_n(rst_n), .we(wr_en & wr_legal), .idx(wr_idx),
        .width(width_e'(wr_width)), .wdata(wr_data), .file(file));

    mwrf_read_port #(.NREG(NREG), .WW(WW)) u_rd0 (
        .file(file), .idx(rd0_idx), .width(width_e'(rd0_width)),
        .legal(rd0_legal), .data(rd0_data));
    mwrf_read_port #(.NREG(NREG), .WW(WW)) u_rd1 (
        .file(file), .idx(rd1_idx), .width(width_e'(rd1_width)),
        .legal(rd1_legal), .data(rd1_data));

    assign sp_value = file[NREG-1];

    // R7: a blocked write leaves the file untouched
    assert_blocked_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_err |=> $stable(file));

    // R7: misaligned quad read raises error and reads zero
    assert_quad_misalign_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd0_width == 2'b11 && rd0_idx[1:0] != 2'b00) |-> (rd0_err && rd0_data == '0));

    // R2: word reads are zero-extended
    assert_word_zero_ext_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd1_width == 2'b01) |-> (rd1_data[DW-1:WW] == '0));

    // R9: a word write to the top register appears on the stack-pointer output
    assert_sp_update_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_width == 2'b01 && wr_idx == IW'(NREG-1)) |=>
        sp_value == $past(wr_data[WW-1:0]));
endmodule

// File: tb/mwrf_top_tb.sv
module mwrf_top_tb;
    localparam int PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        wr_en;
    logic [3:0]  wr_idx;
    logic [1:0]  wr_width;
    logic [63:0] wr_data;
    logic        wr_err;
    logic [3:0]  rd0_idx, rd1_idx;
    logic [1:0]  rd0_width, rd1_width;
    logic [63:0] rd0_data, rd1_data;
    logic        rd0_err, rd1_err;
    logic [15:0] sp_value;

    int checks = 0;
    int fails  = 0;
    logic [15:0] m [16];

    always #(PERIOD/2) clk = ~clk;

    mwrf_top u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_width(wr_width), .wr_data(wr_data), .wr_err(wr_err),
        .rd0_idx(rd0_idx), .rd0_width(rd0_width), .rd0_data(rd0_data), .rd0_err(rd0_err),
        .rd1_idx(rd1_idx), .rd1_width(rd1_width), .rd1_data(rd1_data), .rd1_err(rd1_err),
        .sp_value(sp_value));

    function automatic bit bad(input logic [3:0] i, input logic [1:0] w);
        return (w == 2'b10 && i % 2 != 0) || (w == 2'b11 && i % 4 != 0);
    endfunction

    function automatic logic [63:0] model_read(input logic [3:0] i, input logic [1:0] w);
        logic [63:0] v = '0;
        if (bad(i, w)) return '0;
        case (w)
            2'b00: v[7:0] = i[3] ? m[i[2:0]][7:0] : m[i[2:0]][15:8];
            2'b01: v[15:0] = m[i];
            2'b10: v[31:0] = {m[i], m[i+1]};
            default: v = {m[i], m[i+1], m[i+2], m[i+3]};
        endcase
        return v;
    endfunction

    task automatic model_write(input logic [3:0] i, input logic [1:0] w, input logic [63:0] d);
        case (w)
            2'b00: if (i[3]) m[i[2:0]][7:0] = d[7:0]; else m[i[2:0]][15:8] = d[7:0];
            2'b01: m[i] = d[15:0];
            2'b10: begin m[i] = d[31:16]; m[i+1] = d[15:0]; end
            default: for (int k = 0; k < 4; k++) m[i+k] = d[63-16*k -: 16];
        endcase
    endtask

    task automatic chk(input string tag, input string what, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s %s got %h expected %h", tag, what, got, exp);
        end
    endtask

    task automatic step(input logic we, input logic [3:0] wi, input logic [1:0] ww,
                        input logic [63:0] wd, input logic [3:0] r0i, input logic [1:0] r0w,
                        input logic [3:0] r1i, input logic [1:0] r1w, input string tag);
        @(negedge clk);
        wr_en = we; wr_idx = wi; wr_width = ww; wr_data = wd;
        rd0_idx = r0i; rd0_width = r0w; rd1_idx = r1i; rd1_width = r1w;
        #1;
        chk(tag, "rd0_data", rd0_data, model_read(r0i, r0w));
        chk(tag, "rd0_err", 64'(rd0_err), 64'(bad(r0i, r0w)));
        chk(tag, "rd1_data", rd1_data, model_read(r1i, r1w));
        chk(tag, "rd1_err", 64'(rd1_err), 64'(bad(r1i, r1w)));
        chk(tag, "wr_err", 64'(wr_err), 64'(we && bad(wi, ww)));
        chk(tag, "sp_value", 64'(sp_value), 64'(m[15]));
        @(posedge clk);
        if (we && !bad(wi, ww)) model_write(wi, ww, wd);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

    initial begin
        for (int k = 0; k < 16; k++) m[k] = '0;
        rst_n = 1'b0; wr_en = 0; wr_idx = 0; wr_width = 0; wr_data = 0;
        rd0_idx = 0; rd0_width = 0; rd1_idx = 0; rd1_width = 0;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        // R1: everything reads zero after reset
        for (int k = 0; k < 16; k++) step(0, 0, 0, 0, 4'(k), 2'b01, 4'(k), 2'b00, "R1");
        step(0, 0, 0, 0, 0, 2'b11, 12, 2'b11, "R1");
        // R2 / R8: word write, same-cycle read sees old value
        step(1, 5, 2'b01, 64'hBEEF, 5, 2'b01, 4, 2'b10, "R8");
        step(0, 0, 0, 0, 5, 2'b01, 5, 2'b00, "R2");
        // R3: double-word
        step(1, 2, 2'b10, 64'h1111_2222, 2, 2'b10, 3, 2'b01, "R3");
        step(0, 0, 0, 0, 2, 2'b10, 3, 2'b01, "R3");
        // R4: quad
        step(1, 8, 2'b11, 64'h0123_4567_89AB_CDEF, 8, 2'b11, 9, 2'b01, "R4");
        step(0, 0, 0, 0, 8, 2'b11, 11, 2'b01, "R4");
        // R5: byte writes and reads
        step(1, 4'b1011, 2'b00, 64'h5A, 3, 2'b01, 4'b0011, 2'b00, "R5");
        step(1, 4'b0011, 2'b00, 64'hC3, 3, 2'b01, 4'b1011, 2'b00, "R5");
        step(0, 0, 0, 0, 3, 2'b01, 4'b0011, 2'b00, "R5");
        // R7: misaligned writes blocked, misaligned reads flagged
        step(1, 3, 2'b10, 64'hFFFF_FFFF, 6, 2'b11, 3, 2'b10, "R7");
        step(1, 9, 2'b11, '1, 2, 2'b10, 8, 2'b11, "R7");
        step(0, 0, 0, 0, 3, 2'b01, 4, 2'b01, "R7");
        // R9: stack pointer
        step(1, 15, 2'b01, 64'h7FF0, 15, 2'b01, 14, 2'b10, "R9");
        step(1, 12, 2'b11, 64'hAAAA_BBBB_CCCC_DDDD, 15, 2'b01, 12, 2'b11, "R9");
        step(0, 0, 0, 0, 12, 2'b11, 14, 2'b10, "R9");
        // R6 / R10: mixed traffic against the model
        for (int n = 0; n < 3000; n++)
            step(1'($urandom), 4'($urandom), 2'($urandom), {$urandom, $urandom},
                 4'($urandom), 2'($urandom), 4'($urandom), 2'($urandom), "R6_R10");
        $display("  [TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end
endmodule